// File: doc/BRIEF.md
# I2C Transmit Byte Queue

This block holds up to 64 outgoing bytes in front of an I2C byte shifter and feeds them to it one at a time. Once the queue is switched on, software writes bytes into a data port. The engine then hands each byte to the shifter and waits until the shifter reports that the acknowledge slot is over before it offers the next byte. START and STOP generation and bus clock division sit outside this block.

When the last queued byte is acknowledged, a sticky "drained" status bit is set. If the receiver answers any byte with NAK, the engine records the NAK, raises a status bit and sends nothing more until software flushes the queue. The flush control bit clears itself. It resets both queue pointers and removes the NAK hold. Writing a byte into a full queue loses that byte and sets an overflow status bit. Each status bit stays set until software writes 1 to it.

Top module: `i2c_txq`

## Requirements
- R1: After reset the queue is disabled and empty (`q_level` = 0, `q_empty` = 1), `irq_stat` = 0, `nak_seen` = 0 and `sh_valid` = 0.
- R2: A `data_wr` pulse while `ctl_en` = 1 queues `data_in[7:0]` and raises `q_level` by one in the next cycle. The upper bits of `data_in` are dropped.
- R3: A `data_wr` pulse while `ctl_en` = 0 leaves `q_level` unchanged and queues no byte.
- R4: Queued bytes go to the shifter in write order. After a byte is accepted (`sh_valid` and `sh_ready`), `sh_valid` stays low until the shifter pulses `sh_done` for that byte.
- R5: When `sh_done` arrives with `sh_nak` = 0 and the queue is empty, `irq_stat[1]` (drained) is set in the next cycle.
- R6: When `sh_done` arrives with `sh_nak` = 1, `irq_stat[0]` and `nak_seen` are set, and no further byte is offered until a flush.
- R7: A `ctl_wr` with `ctl_in[7]` = 1 makes `ctl_flush` read 1 for exactly one cycle. In the cycle after that, `q_level` is 0 and `nak_seen` is 0. `ctl_in[6]` sets `ctl_en` on every `ctl_wr`.
- R8: A `data_wr` while the queue holds 64 bytes leaves `q_level` at 64 and sets `irq_stat[2]` (overflow).
- R9: A `stat_clr_wr` clears each `irq_stat` bit whose `stat_clr_in` bit is 1 and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_wr | input | 1 | Data port write strobe |
| data_in | input | 32 | Data port write value; only bits 7:0 are used |
| ctl_wr | input | 1 | Control write strobe |
| ctl_in | input | 8 | Control value: bit 6 enables the queue, bit 7 flushes it |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_in | input | 3 | Status bits to clear (write 1 to clear) |
| sh_valid | output | 1 | A byte is offered to the shifter |
| sh_data | output | 8 | Offered byte |
| sh_ready | input | 1 | Shifter can take a byte |
| sh_done | input | 1 | Shifter finished a byte and its acknowledge slot |
| sh_nak | input | 1 | Qualifies `sh_done`: the byte was answered with NAK |
| ctl_en | output | 1 | Queue enable readback |
| ctl_flush | output | 1 | Flush bit readback (self-clearing) |
| nak_seen | output | 1 | NAK recorded; queue is held |
| q_empty | output | 1 | Queue holds no bytes |
| q_level | output | 7 | Number of queued bytes |
| irq_stat | output | 3 | Sticky status: bit 0 NAK, bit 1 drained, bit 2 overflow |

## Verification
On every cycle, the assertions check that only one byte is with the shifter at a time and that nothing is offered while the NAK hold is active. They also check that the level never passes the depth and does not grow once the queue is full, that a flush leaves the queue empty one cycle later, and that a clean final acknowledge sets the drained bit. Other behaviours can only be shown by the bench's scenarios with a modelled shifter: that bytes come out in write order with their upper bits dropped, that writes are ignored while the queue is off, that the NAK lands on the right byte with the rest held back, and that status bits clear individually.

// File: rtl/i2c_txq.sv
module i2c_txq #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] data_in,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_in,
  input  logic          stat_clr_wr,
  input  logic [2:0]    stat_clr_in,
  output logic          sh_valid,
  output logic [7:0]    sh_data,
  input  logic          sh_ready,
  input  logic          sh_done,
  input  logic          sh_nak,
  output logic          ctl_en,
  output logic          ctl_flush,
  output logic          nak_seen,
  output logic          q_empty,
  output logic [AW:0]   q_level,
  output logic [2:0]    irq_stat
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic          busy;

  wire full  = q_level == (AW+1)'(DEPTH);
  wire wr_ok = data_wr & ctl_en & ~ctl_flush;
  wire push  = wr_ok & ~full;
  wire drop  = wr_ok & full;
  wire pop   = sh_valid & sh_ready;
  wire fin   = sh_done & busy;

  assign q_empty  = q_level == '0;
  assign sh_valid = ctl_en & ~q_empty & ~busy & ~nak_seen & ~ctl_flush;
  assign sh_data  = mem[rd_p];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) if (push) mem[wr_p] <= data_in[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en    <= 1'b0;
      ctl_flush <= 1'b0;
    end else begin
      ctl_flush <= ctl_wr & ctl_in[7];
      if (ctl_wr) ctl_en <= ctl_in[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p    <= '0;
      wr_p    <= '0;
      q_level <= '0;
    end else if (ctl_flush) begin
      rd_p    <= '0;
      wr_p    <= '0;
      q_level <= '0;
    end else begin
      if (push) wr_p <= nxt(wr_p);
      if (pop)  rd_p <= nxt(rd_p);
      q_level <= q_level + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      nak_seen <= 1'b0;
    end else begin
      if (pop)      busy <= 1'b1;
      else if (fin) busy <= 1'b0;
      if (ctl_flush)        nak_seen <= 1'b0;
      else if (fin & sh_nak) nak_seen <= 1'b1;
    end
  end

  logic [2:0] set_v, clr_v;
  assign set_v = {drop, fin & ~sh_nak & q_empty, fin & sh_nak};
  assign clr_v = stat_clr_wr ? stat_clr_in : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_stat <= '0;
    else        irq_stat <= set_v | (irq_stat & ~clr_v);
  end

  // R4
  one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_ready) |=> !sh_valid);

  // R6
  nak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak_seen |-> !sh_valid);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= (AW+1)'(DEPTH));

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ctl_en && !ctl_flush && full && !pop) |=> (full && irq_stat[2]));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_flush |=> (q_empty && !nak_seen));

  // R5
  drain_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && busy && !sh_nak && q_empty) |=> irq_stat[1]);

endmodule

// File: tb/i2c_txq_bench.sv
module i2c_txq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0;
  logic data_wr = 0, ctl_wr = 0, stat_clr_wr = 0;
  logic [31:0] data_in = 0;
  logic [7:0] ctl_in = 0;
  logic [2:0] stat_clr_in = 0;
  logic sh_valid, sh_ready, ctl_en, ctl_flush, nak_seen, q_empty;
  logic sh_done = 0, sh_nak = 0;
  logic [7:0] sh_data;
  logic [6:0] q_level;
  logic [2:0] irq_stat;

  int checks = 0, fails = 0;
  logic fin_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_txq u_i2c_txq (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
    .ctl_wr(ctl_wr), .ctl_in(ctl_in), .stat_clr_wr(stat_clr_wr), .stat_clr_in(stat_clr_in),
    .sh_valid(sh_valid), .sh_data(sh_data), .sh_ready(sh_ready), .sh_done(sh_done), .sh_nak(sh_nak),
    .ctl_en(ctl_en), .ctl_flush(ctl_flush), .nak_seen(nak_seen), .q_empty(q_empty),
    .q_level(q_level), .irq_stat(irq_stat));

  // shifter model
  logic m_busy = 0, rdy_en = 0;
  int m_cnt = 0, nsent = 0, nak_at = -1;
  logic [7:0] sent [32];
  assign sh_ready = rdy_en & ~m_busy;

  always @(posedge clk) begin
    sh_done <= 1'b0;
    sh_nak  <= 1'b0;
    if (m_busy) begin
      if (m_cnt == 0) begin
        m_busy  <= 1'b0;
        sh_done <= 1'b1;
        sh_nak  <= (nsent - 1 == nak_at);
      end else m_cnt <= m_cnt - 1;
    end else if (sh_valid && sh_ready) begin
      if (nsent < 32) sent[nsent] <= sh_data;
      nsent  <= nsent + 1;
      m_busy <= 1'b1;
      m_cnt  <= 2;
    end
  end

  localparam logic [31:0] VEC [8] = '{
    32'h0000_0011, 32'hABCD_EF5A, 32'h0000_00FF, 32'h1234_5600,
    32'h0000_0080, 32'hFFFF_FF01, 32'h0000_003C, 32'h8000_00C3};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk); data_wr = 1; data_in = v;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1; ctl_in = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic clr(input logic [2:0] v);
    @(negedge clk); stat_clr_wr = 1; stat_clr_in = v;
    @(negedge clk); stat_clr_wr = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin_run) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 level", q_level, 0);
    check("R1 empty", q_empty, 1);
    check("R1 irq", irq_stat, 0);
    check("R1 nak", nak_seen, 0);
    check("R1 valid", sh_valid, 0);

    // R3 write while disabled
    push(32'h55);
    check("R3 level", q_level, 0);
    check("R3 empty", q_empty, 1);

    // R2 table walk with shifter stalled
    ctl(8'h40);
    check("R7 enable", ctl_en, 1);
    for (int i = 0; i < 8; i++) begin
      push(VEC[i]);
      check("R2 level", q_level, i + 1);
    end
    check("R2 empty", q_empty, 0);

    // R4/R5 drain
    @(negedge clk); rdy_en = 1;
    for (int k = 0; k < 200 && !irq_stat[1]; k++) @(negedge clk);
    check("R4 count", nsent, 8);
    for (int i = 0; i < 8; i++) check("R4 order", sent[i], int'(VEC[i][7:0]));
    check("R5 drained", irq_stat[1], 1);
    check("R5 empty", q_empty, 1);
    check("R5 no nak", irq_stat[0], 0);

    // R9 clear only drained
    clr(3'b010);
    check("R9 cleared", irq_stat, 0);

    // R6 NAK on second byte of a new batch
    @(negedge clk); rdy_en = 0;
    base = nsent;
    nak_at = base + 1;
    push(32'hA1); push(32'hA2); push(32'hA3); push(32'hA4);
    @(negedge clk); rdy_en = 1;
    repeat (40) @(negedge clk);
    check("R6 sent", nsent - base, 2);
    check("R6 nak flag", nak_seen, 1);
    check("R6 irq", irq_stat[0], 1);
    check("R6 level held", q_level, 2);
    check("R6 valid low", sh_valid, 0);
    check("R6 not drained", irq_stat[1], 0);

    // R7 flush
    @(negedge clk); ctl_wr = 1; ctl_in = 8'hC0;
    @(negedge clk); ctl_wr = 0;
    check("R7 flush bit", ctl_flush, 1);
    @(negedge clk);
    check("R7 flush self-clear", ctl_flush, 0);
    check("R7 level", q_level, 0);
    check("R7 nak cleared", nak_seen, 0);
    check("R7 enable kept", ctl_en, 1);
    repeat (10) @(negedge clk);
    check("R7 nothing sent", nsent - base, 2);

    // R9 partial clear keeps others
    check("R9 nak kept", irq_stat[0], 1);
    clr(3'b100);
    check("R9 nak still kept", irq_stat[0], 1);
    clr(3'b001);
    check("R9 nak cleared", irq_stat, 0);

    // R8 full queue
    @(negedge clk); rdy_en = 0;
    for (int i = 0; i < DEPTH; i++) push(32'(i));
    check("R8 full level", q_level, DEPTH);
    check("R8 no err yet", irq_stat[2], 0);
    push(32'hEE);
    check("R8 dropped level", q_level, DEPTH);
    check("R8 overflow", irq_stat[2], 1);
    ctl(8'hC0);
    @(negedge clk);
    check("R7 flush full", q_level, 0);

    fin_run = 1;
    summary();
    $finish;
  end
endmodule